// File: doc/BRIEF.md
# Exhaustive input transition sequencer

This block drives an n-bit stimulus bus so that every possible change of a target's inputs is applied exactly once. Over one run it visits the 2^n vectors in an order where each ordered pair of distinct vectors (a then b, with a different from b) appears as two consecutive vectors exactly once, and no vector ever follows itself. One run therefore holds 2^(2n) - 2^n transitions: 992 for n = 5, 56 for n = 3. Each transition is one analysis frame, during which a power or leakage checker watching the target can attribute its observation to the pair.

The walk is deterministic. It first climbs 0, 1, ..., 2^n - 1. It then works down a hub vertex h from 2^n - 2 to 0. It steps back to each new hub from the hub above it, and from every hub it makes an out-and-back excursion to each vertex at least two above it. The walk ends on vector 0. The frame is offered on a valid/ready stream. `frame_valid` means the pair (`vec_prev`, `vec_cur`) is a new, unconsumed transition. `advance` is the consumer's ready. A frame is taken in the cycle both are high. While `advance` is low the frame is held unchanged, however long the stall lasts. A one-cycle `start` launches a run from idle or from done. `done` rises after the last frame is taken and stays high until the next start. The parameter `VEC_W` sets n and is intended for 1 to 16 bits.

Top module: `trans_sweep`

## Requirements
- R1: While `rst` is high (synchronous), and in the cycle after it, `vec_cur` = 0, `vec_prev` = 0, `frame_valid` = 0 and `done` = 0.
- R2: A `start` pulse seen while not running makes the next cycle show `frame_valid` = 1 with the first frame `vec_prev` = 0, `vec_cur` = 1, and `done` = 0.
- R3: Whenever `frame_valid` is 1, `vec_prev` differs from `vec_cur`.
- R4: For every taken frame except the last, the next frame's `vec_prev` equals the taken frame's `vec_cur`, and the next frame is offered in the following cycle.
- R5: One run takes exactly 2^n·(2^n - 1) frames, and every ordered pair of distinct vectors appears as (`vec_prev`, `vec_cur`) in exactly one of them.
- R6: While `frame_valid` is 1 and `advance` is 0, the next cycle shows the same `vec_prev`, `vec_cur` and `frame_valid` = 1.
- R7: The last frame of a run is (2^n - 1 -> 0). In the cycle after it is taken, `frame_valid` = 0 and `done` = 1. Both vectors then hold that last frame until the next start.
- R8: A `start` pulse while `frame_valid` is 1 has no effect: the walk continues per R4, including when it falls in the same cycle as taking the last frame.
- R9: A `start` pulse while `done` is 1 clears `done` and begins a fresh run per R2.
- R10: The first 2^n - 1 frames climb: frame i (counting from 0) is (i -> i + 1).
- R11: `advance` while `frame_valid` is 0 (idle or done) changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch of a run |
| advance | input | 1 | Ready from the frame consumer |
| frame_valid | output | 1 | A new transition is on the vector outputs |
| vec_cur | output | VEC_W | Vector applied to the target in this frame |
| vec_prev | output | VEC_W | Vector applied in the frame before |
| done | output | 1 | Run complete, held until the next start |

## Verification
Two events can coincide in one cycle: the consumer taking the final frame, and a new `start` pulse. If the start won, a fresh run would begin. If it were half taken, `done` could rise together with a new valid frame. The bench raises `start` in exactly the cycle where the last frame is taken, during a run with periodic stalls. It judges the outcome from the next cycle: `done` high, `frame_valid` low and the vectors frozen on (2^n - 1 -> 0). A later isolated start must then launch a clean run beginning with (0 -> 1).

// File: rtl/trans_sweep_pkg.sv
package trans_sweep_pkg;

  // Position of the walk inside its construction.
  typedef enum logic [1:0] {
    PH_CLIMB = 2'd0,  // ascending 0 .. top
    PH_HUB   = 2'd1,  // sitting on the hub vertex
    PH_AWAY  = 2'd2   // out on an excursion from the hub
  } walk_ph_e;

  // Run-level control state.
  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,
    RUN_BUSY = 2'd1,
    RUN_DONE = 2'd2
  } run_st_e;

endpackage

// File: rtl/trans_sweep_step.sv
module trans_sweep_step
  import trans_sweep_pkg::*;
#(
  parameter int unsigned VEC_W = 4
) (
  input  walk_ph_e         ph_i,
  input  logic [VEC_W-1:0] cur_i,
  input  logic [VEC_W-1:0] hub_i,
  input  logic [VEC_W:0]   reach_i,
  output walk_ph_e         ph_o,
  output logic [VEC_W-1:0] cur_o,
  output logic [VEC_W-1:0] hub_o,
  output logic [VEC_W:0]   reach_o,
  output logic             end_o
);

  localparam int unsigned    NV      = 1 << VEC_W;
  localparam logic [VEC_W-1:0] TOPV  = VEC_W'(NV - 1);
  localparam logic [VEC_W-1:0] BELOW = VEC_W'(NV - 2);
  localparam logic [VEC_W:0]   LIMIT = (VEC_W+1)'(NV);

  // Successor of the walk state; end_o marks a state with no unused edge.
  always_comb begin
    ph_o    = ph_i;
    cur_o   = cur_i;
    hub_o   = hub_i;
    reach_o = reach_i;
    end_o   = 1'b0;
    unique case (ph_i)
      PH_CLIMB: begin
        if (cur_i != TOPV) begin
          cur_o = cur_i + VEC_W'(1);
        end else begin
          // step down onto the first hub; it has no excursion targets
          cur_o   = BELOW;
          hub_o   = BELOW;
          reach_o = LIMIT;
          ph_o    = PH_HUB;
        end
      end
      PH_HUB: begin
        if (reach_i < LIMIT) begin
          cur_o = reach_i[VEC_W-1:0];
          ph_o  = PH_AWAY;
        end else if (hub_i == '0) begin
          end_o = 1'b1;
        end else begin
          // move to the next hub below; its excursions start two above it
          cur_o   = hub_i - VEC_W'(1);
          hub_o   = hub_i - VEC_W'(1);
          reach_o = {1'b0, hub_i} + (VEC_W+1)'(1);
          ph_o    = PH_HUB;
        end
      end
      PH_AWAY: begin
        cur_o   = hub_i;
        reach_o = reach_i + (VEC_W+1)'(1);
        ph_o    = PH_HUB;
      end
      default: begin
        end_o = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/trans_sweep_ctr.sv
module trans_sweep_ctr #(
  parameter int unsigned     CNT_W = 8,
  parameter logic [CNT_W-1:0] TOTAL = CNT_W'(12)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      count_q <= '0;
    end else if (step_i) begin
      count_q <= count_q + CNT_W'(1);
    end
  end

  assign count_o = count_q;
  assign last_o  = (count_q == TOTAL - CNT_W'(1));

  // R5: the frame count never runs past one full walk
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    step_i |-> (count_q < TOTAL));

endmodule

// File: rtl/trans_sweep.sv
module trans_sweep
  import trans_sweep_pkg::*;
#(
  parameter int unsigned VEC_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             advance,
  output logic             frame_valid,
  output logic [VEC_W-1:0] vec_cur,
  output logic [VEC_W-1:0] vec_prev,
  output logic             done
);

  localparam int unsigned      NV    = 1 << VEC_W;
  localparam int unsigned      CNT_W = 2 * VEC_W;
  localparam logic [CNT_W-1:0] TOTAL = CNT_W'(longint'(NV) * longint'(NV - 1));

  run_st_e          run_q;
  walk_ph_e         ph_q;
  logic [VEC_W-1:0] cur_q, prev_q, hub_q;
  logic [VEC_W:0]   reach_q;

  walk_ph_e         ph_n;
  logic [VEC_W-1:0] cur_n, hub_n;
  logic [VEC_W:0]   reach_n;
  logic             walk_end;

  logic             take, launch, last_frame;
  logic [CNT_W-1:0] frame_cnt;

  trans_sweep_step #(.VEC_W(VEC_W)) u_step (
    .ph_i   (ph_q),
    .cur_i  (cur_q),
    .hub_i  (hub_q),
    .reach_i(reach_q),
    .ph_o   (ph_n),
    .cur_o  (cur_n),
    .hub_o  (hub_n),
    .reach_o(reach_n),
    .end_o  (walk_end)
  );

  trans_sweep_ctr #(.CNT_W(CNT_W), .TOTAL(TOTAL)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .clear_i(launch),
    .step_i (take),
    .count_o(frame_cnt),
    .last_o (last_frame)
  );

  assign frame_valid = (run_q == RUN_BUSY);
  assign done        = (run_q == RUN_DONE);
  assign take        = frame_valid && advance;
  assign launch      = start && (run_q != RUN_BUSY);
  assign vec_cur     = cur_q;
  assign vec_prev    = prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= RUN_IDLE;
      ph_q    <= PH_CLIMB;
      cur_q   <= '0;
      prev_q  <= '0;
      hub_q   <= '0;
      reach_q <= '0;
    end else begin
      unique case (run_q)
        RUN_IDLE, RUN_DONE: begin
          if (start) begin
            run_q   <= RUN_BUSY;
            ph_q    <= PH_CLIMB;
            prev_q  <= '0;
            cur_q   <= VEC_W'(1);
            hub_q   <= '0;
            reach_q <= '0;
          end
        end
        RUN_BUSY: begin
          if (take) begin
            if (last_frame) begin
              run_q <= RUN_DONE;
            end else begin
              prev_q  <= cur_q;
              cur_q   <= cur_n;
              ph_q    <= ph_n;
              hub_q   <= hub_n;
              reach_q <= reach_n;
            end
          end
        end
        default: run_q <= RUN_IDLE;
      endcase
    end
  end

  // R1: nothing offered and nothing finished straight out of reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!frame_valid && !done && vec_cur == '0 && vec_prev == '0));

  // R2: a launch presents the opening pair 0 -> 1
  a_r2_first_pair: assert property (@(posedge clk) disable iff (rst)
    launch |=> (frame_valid && !done && vec_prev == '0 && vec_cur == VEC_W'(1)));

  // R3: an offered frame is never a self transition
  a_r3_no_self: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (vec_prev != vec_cur));

  // R4: frames chain head to tail
  a_r4_chain: assert property (@(posedge clk) disable iff (rst)
    (take && !last_frame) |=> (frame_valid && vec_prev == $past(vec_cur)));

  // R5: the frame counter and the walk agree on where the run ends
  a_r5_end_agree: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (last_frame == walk_end));

  // R6: a stalled frame is held
  a_r6_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && !advance) |=> (frame_valid && $stable(vec_cur) && $stable(vec_prev)));

  // R7: taking the last frame ends the run
  a_r7_finish: assert property (@(posedge clk) disable iff (rst)
    (take && last_frame) |=> (done && !frame_valid));

  // R7: valid and done never overlap
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(frame_valid && done));

endmodule

// File: tb/trans_sweep_bench.sv
module trans_sweep_bench;

  localparam int VW    = 3;
  localparam int NV    = 1 << VW;
  localparam int TOTAL = NV * (NV - 1);

  logic          clk = 1'b0;
  logic          rst, start, advance;
  logic          frame_valid, done;
  logic [VW-1:0] vec_cur, vec_prev;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  trans_sweep #(.VEC_W(VW)) u_trans_sweep (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .advance    (advance),
    .frame_valid(frame_valid),
    .vec_cur    (vec_cur),
    .vec_prev   (vec_prev),
    .done       (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_quiet(input string req, input int want_done,
                           input int want_prev, input int want_cur);
    chk(frame_valid == 1'b0, req, "frame_valid", int'(frame_valid), 0);
    chk(done == want_done[0], req, "done", int'(done), want_done);
    chk(int'(vec_prev) == want_prev, req, "vec_prev", int'(vec_prev), want_prev);
    chk(int'(vec_cur) == want_cur, req, "vec_cur", int'(vec_cur), want_cur);
  endtask

  // One full run; stall=1 uses periodic back-pressure, a mid-run start and
  // a start coinciding with the last accepted frame.
  task automatic run_walk(input bit stall);
    bit           seen [NV*NV];
    int           got = 0;
    int           cyc = 0;
    int           last_cur = 0;
    bit           have = 1'b0;
    bit           held = 1'b0;
    int           sp = 0, sc = 0;
    int           hits = 0;
    for (int i = 0; i < NV*NV; i++) seen[i] = 1'b0;
    while (got < TOTAL) begin
      @(negedge clk);
      cyc++;
      if (held) begin
        chk(frame_valid && int'(vec_prev) == sp && int'(vec_cur) == sc, "R6",
            "stalled frame changed", int'(vec_prev) * NV + int'(vec_cur), sp * NV + sc);
      end
      if (!frame_valid) begin
        chk(1'b0, "R4", "frame_valid dropped mid-run", got, TOTAL);
        break;
      end
      advance = stall ? ((cyc % 3) != 0) : 1'b1;
      start   = stall && advance && (got == 20 || got == TOTAL - 1);
      if (advance) begin
        chk(vec_prev != vec_cur, "R3", "self transition", int'(vec_prev), int'(vec_cur));
        if (have)
          chk(int'(vec_prev) == last_cur, "R4", "chain broken", int'(vec_prev), last_cur);
        if (got < NV - 1) begin
          chk(int'(vec_prev) == got && int'(vec_cur) == got + 1, "R10", "climb frame",
              int'(vec_prev) * NV + int'(vec_cur), got * NV + got + 1);
        end
        if (got == TOTAL - 1) begin
          chk(int'(vec_prev) == NV - 1 && int'(vec_cur) == 0, "R7", "last frame",
              int'(vec_prev) * NV + int'(vec_cur), (NV - 1) * NV);
        end
        if (seen[int'(vec_prev) * NV + int'(vec_cur)])
          chk(1'b0, "R5", "repeated pair", int'(vec_prev) * NV + int'(vec_cur), -1);
        seen[int'(vec_prev) * NV + int'(vec_cur)] = 1'b1;
        last_cur = int'(vec_cur);
        have = 1'b1;
        got++;
      end
      held = !advance;
      sp = int'(vec_prev);
      sc = int'(vec_cur);
    end
    @(negedge clk);
    advance = 1'b0;
    start   = 1'b0;
    chk_quiet("R7", 1, NV - 1, 0);
    for (int p = 0; p < NV; p++) begin
      for (int c = 0; c < NV; c++) begin
        if (seen[p * NV + c]) hits++;
        if (p == c && seen[p * NV + c])
          chk(1'b0, "R3", "self pair recorded", p, -1);
        if (p != c && !seen[p * NV + c])
          chk(1'b0, "R5", "missing pair", p * NV + c, 1);
      end
    end
    chk(hits == TOTAL, "R5", "distinct pairs covered", hits, TOTAL);
    chk(got == TOTAL, "R5", "frames in run", got, TOTAL);
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; advance = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_quiet("R1", 0, 0, 0);
    rst = 1'b0;
    advance = 1'b1;
    @(negedge clk);
    chk_quiet("R1", 0, 0, 0);
    @(negedge clk);
    chk_quiet("R11", 0, 0, 0);

    // first run, no back-pressure
    advance = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(frame_valid && !done && vec_prev == 0 && int'(vec_cur) == 1, "R2", "opening frame",
        int'(vec_prev) * NV + int'(vec_cur), 1);
    run_walk(1'b0);

    // idle in done with advance high: nothing moves
    advance = 1'b1;
    repeat (3) @(negedge clk);
    chk_quiet("R11", 1, NV - 1, 0);

    // second run with stalls and coinciding start pulses
    advance = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(frame_valid && !done && vec_prev == 0 && int'(vec_cur) == 1, "R9", "restart frame",
        int'(vec_prev) * NV + int'(vec_cur), 1);
    run_walk(1'b1);
    repeat (2) @(negedge clk);
    chk_quiet("R8", 1, NV - 1, 0);

    // third launch, then reset in the middle of the run
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(frame_valid && !done && vec_prev == 0 && int'(vec_cur) == 1, "R9", "third launch",
        int'(vec_prev) * NV + int'(vec_cur), 1);
    advance = 1'b1;
    repeat (10) @(negedge clk);
    advance = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk_quiet("R1", 0, 0, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule